// File: doc/BRIEF.md
# Falling Ramp Slope-Compensation Generator

This block produces a digital falling ramp used as the reference code of a comparator DAC in peak current mode control. A wide countdown accumulator is loaded with a peak value at the start of each switching period and then reduced by a programmable step on every clock. The DAC code is taken from the accumulator's upper bits. The discarded low bits act as a fractional prescale, so the slope can be finer than one DAC LSB per cycle.

The peak value and the step are captured only when a reload strobe arrives, so a ramp already running is never disturbed partway through. The reload strobe is usually tied to the start of the PWM period. When ramp mode is off, the accumulator is frozen and the DAC code comes from a static code input.

All pins are plain control and status signals. The block has no streaming interface and no back-pressure.

Top module: `slope_ramp_gen`

## Requirements
- R1: Reset clears the accumulator and the latched step to zero. After reset, with ramp mode on and no reload, `ramp_sts_o` stays 0.
- R2: With ramp mode on (`ramp_mode_i`=1) and no reload, `ramp_sts_o` drops on each clock by the latched step. It never rises.
- R3: In ramp mode, `dac_code_o` equals `ramp_sts_o[15:4]` (the upper DAC_W bits). With a step below 16, the code changes only every few cycles.
- R4: A reload in ramp mode sets `ramp_sts_o` to `peak_ref_i` on the next edge and latches `dec_step_i`. A reload takes priority over the decrement in the same cycle.
- R5: The accumulator saturates at 0. A decrement larger than the current value leaves 0, and it stays 0 until the next reload.
- R6: Changes on `peak_ref_i` or `dec_step_i` between reloads have no effect on `ramp_sts_o` until the next reload.
- R7: With ramp mode off, `ramp_sts_o` holds its value, reload strobes are ignored, and `dac_code_o` equals `static_code_i`.
- R8: A latched step of zero keeps `ramp_sts_o` flat at the loaded peak until the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ramp_mode_i | input | 1 | 1 selects the ramp, 0 selects the static code |
| reload_i | input | 1 | One-cycle reload strobe (period start) |
| peak_ref_i | input | 16 | Peak value loaded at reload |
| dec_step_i | input | 16 | Decrement step, latched at reload |
| static_code_i | input | 12 | DAC code used when ramp mode is off |
| dac_code_o | output | 12 | DAC reference code |
| ramp_sts_o | output | 16 | Raw accumulator value |

## Verification
The bench builds the block with its default widths: a 16-bit accumulator and a 12-bit code, which leaves four fraction bits. With these values, steps below 16 exercise the sub-LSB code cadence. Peaks near full scale and small peaks next to large steps reach both ends of the accumulator range, including saturation at zero. Peak and step changes in the middle of a ramp, and reloads while ramp mode is off, confirm that only a reload in ramp mode changes the ramp.

// File: rtl/rg_pkg.sv
package rg_pkg;
  typedef enum logic {SRC_STATIC = 1'b0, SRC_RAMP = 1'b1} code_src_e;
endpackage

// File: rtl/rg_step_latch.sv
module rg_step_latch #(
  parameter int ACC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [ACC_W-1:0] step_i,
  output logic [ACC_W-1:0] step_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni)     step_o <= '0;
    else if (load_i) step_o <= step_i;
  end
endmodule

// File: rtl/rg_down_acc.sv
module rg_down_acc #(
  parameter int ACC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [ACC_W-1:0] peak_i,
  input  logic [ACC_W-1:0] step_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] dec_val;
  logic             underflow;

  always_comb begin
    underflow = (acc_o < step_i);
    dec_val   = underflow ? '0 : (acc_o - step_i);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     acc_o <= '0;
    else if (run_i) begin
      if (load_i)    acc_o <= peak_i;
      else           acc_o <= dec_val;
    end
  end
endmodule

// File: rtl/rg_code_sel.sv
module rg_code_sel
  import rg_pkg::*;
#(
  parameter int ACC_W = 16,
  parameter int DAC_W = 12
) (
  input  code_src_e        src_i,
  input  logic [ACC_W-1:0] acc_i,
  input  logic [DAC_W-1:0] static_i,
  output logic [DAC_W-1:0] code_o
);
  localparam int FRAC_W = ACC_W - DAC_W;
  logic [DAC_W-1:0] ramp_code;

  generate
    if (FRAC_W > 0) begin : g_frac
      assign ramp_code = acc_i[ACC_W-1:FRAC_W];
    end else begin : g_nofrac
      assign ramp_code = acc_i[DAC_W-1:0];
    end
  endgenerate

  always_comb code_o = (src_i == SRC_RAMP) ? ramp_code : static_i;
endmodule

// File: rtl/slope_ramp_gen.sv
module slope_ramp_gen
  import rg_pkg::*;
#(
  parameter int ACC_W = 16,
  parameter int DAC_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ramp_mode_i,
  input  logic             reload_i,
  input  logic [ACC_W-1:0] peak_ref_i,
  input  logic [ACC_W-1:0] dec_step_i,
  input  logic [DAC_W-1:0] static_code_i,
  output logic [DAC_W-1:0] dac_code_o,
  output logic [ACC_W-1:0] ramp_sts_o
);
  code_src_e        src;
  logic             load_evt;
  logic [ACC_W-1:0] step_q;

  assign src      = ramp_mode_i ? SRC_RAMP : SRC_STATIC;
  assign load_evt = ramp_mode_i & reload_i;

  rg_step_latch #(.ACC_W(ACC_W)) i_step (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_evt),
    .step_i(dec_step_i), .step_o(step_q)
  );

  rg_down_acc #(.ACC_W(ACC_W)) i_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(ramp_mode_i), .load_i(reload_i),
    .peak_i(peak_ref_i), .step_i(step_q), .acc_o(ramp_sts_o)
  );

  rg_code_sel #(.ACC_W(ACC_W), .DAC_W(DAC_W)) i_sel (
    .src_i(src), .acc_i(ramp_sts_o), .static_i(static_code_i), .code_o(dac_code_o)
  );
endmodule

// File: rtl/slope_ramp_gen_chk.sv
module slope_ramp_gen_chk #(
  parameter int ACC_W = 16,
  parameter int DAC_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ramp_mode_i,
  input logic             reload_i,
  input logic [ACC_W-1:0] peak_ref_i,
  input logic [DAC_W-1:0] static_code_i,
  input logic [DAC_W-1:0] dac_code_o,
  input logic [ACC_W-1:0] ramp_sts_o
);
  localparam int FRAC_W = ACC_W - DAC_W;

  AST_RELOAD_LOADS_PEAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ramp_mode_i && reload_i) |=> (ramp_sts_o == $past(peak_ref_i))); // R4
  AST_NEVER_RISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ramp_mode_i && !reload_i) |=> (ramp_sts_o <= $past(ramp_sts_o))); // R2
  AST_ZERO_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ramp_mode_i && !reload_i && ramp_sts_o == '0) |=> (ramp_sts_o == '0)); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ramp_mode_i |=> $stable(ramp_sts_o)); // R7
  AST_STATIC_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ramp_mode_i |-> (dac_code_o == static_code_i)); // R7
  AST_CODE_UPPER_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ramp_mode_i |-> (dac_code_o == DAC_W'(ramp_sts_o >> FRAC_W))); // R3
endmodule

bind slope_ramp_gen slope_ramp_gen_chk #(.ACC_W(ACC_W), .DAC_W(DAC_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ramp_mode_i(ramp_mode_i), .reload_i(reload_i),
  .peak_ref_i(peak_ref_i), .static_code_i(static_code_i),
  .dac_code_o(dac_code_o), .ramp_sts_o(ramp_sts_o)
);

// File: tb/test_slope_ramp_gen.sv
module test_slope_ramp_gen;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        mode = 0, reload = 0;
  logic [15:0] peak = 0, step = 0;
  logic [11:0] stat = 0;
  logic [11:0] dac;
  logic [15:0] sts;

  int n_chk = 0, n_fail = 0;
  int m_sts = 0, m_step = 0;
  int wd = 0;
  string req = "R1";

  always #2 clk = ~clk;

  slope_ramp_gen i_slope_ramp_gen (
    .clk_i(clk), .rst_ni(rst_n), .ramp_mode_i(mode), .reload_i(reload),
    .peak_ref_i(peak), .dec_step_i(step), .static_code_i(stat),
    .dac_code_o(dac), .ramp_sts_o(sts)
  );

  // behavioural reference
  always @(posedge clk) begin
    if (!rst_n) begin
      m_sts = 0; m_step = 0;
    end else if (mode) begin
      if (reload) begin m_sts = peak; m_step = step; end
      else m_sts = (m_sts >= m_step) ? m_sts - m_step : 0;
    end
  end

  function automatic void check(string r, int act, int exp_v, string what);
    n_chk++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp_v);
    end
  endfunction

  always @(negedge clk) if (rst_n) begin
    check(req, sts, m_sts, "ramp_sts");
    check(mode ? "R3" : "R7", dac, mode ? (m_sts >> 4) : stat, "dac_code");
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic do_reload(logic [15:0] p, logic [15:0] s);
    peak = p; step = s; reload = 1;
    cyc(1);
    reload = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 50000) begin
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<=50000", wd);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    cyc(3);
    rst_n = 1; mode = 1;
    check("R1", sts, 0, "reset sts");
    check("R1", dac, 0, "reset dac");
    req = "R1"; cyc(3);
    // R4, R2: full-scale ramp with a large step
    req = "R4"; do_reload(16'hF000, 16'h0100);
    req = "R2"; cyc(20);
    // R3: sub-LSB step, code moves every few cycles
    req = "R3"; do_reload(16'h8000, 16'h0005);
    cyc(40);
    // R6: inputs change mid-ramp without effect
    req = "R6"; peak = 16'h1234; step = 16'h0FFF; cyc(10);
    req = "R4"; do_reload(16'h4000, 16'h0300); cyc(5);
    // R4: reload every cycle beats decrement
    reload = 1; peak = 16'hABCD; cyc(4); reload = 0;
    // R5: saturation at zero
    req = "R5"; do_reload(16'h0030, 16'h0020); cyc(6);
    do_reload(16'hFFFF, 16'hFFF0); cyc(4);
    // R8: zero step flat
    req = "R8"; do_reload(16'h7777, 16'h0000); cyc(10);
    // R7: idle mode, reload ignored, static code
    req = "R7"; do_reload(16'h9000, 16'h0040); cyc(3);
    mode = 0; stat = 12'h5A5; cyc(3);
    reload = 1; peak = 16'h0100; cyc(2); reload = 0;
    stat = 12'h0FF; cyc(3);
    mode = 1; req = "R2"; cyc(5);
    check("R7", (16'h9000 - sts) % 16'h0040, 0, "resume on old ramp");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule